// File: doc/BRIEF.md
# Pipelined Synchronous Burst SRAM Core

This block is a behavioural, synthesizable single-port synchronous SRAM with registered inputs and a registered read path. Each word holds 32 data bits and 4 parity bits, organised as four 9-bit lanes: byte n of the data travels together with parity bit n. The address bus is 17 bits wide, but only the lowest `MEM_AW` bits select a stored word. The upper bits still take part in the burst address. This lets a simulation build use a small array.

An access begins on a rising edge when one of two address strobes is low. The processor strobe always opens a read. It can be turned into a write on the following edge. The controller strobe reads or writes in the same cycle, depending on the write controls. When no strobe is asserted, an active burst continues. The advance input steps a two-bit burst counter, in either linear or interleaved order.

Read data and the output-drive enable come from registers. Output enable acts without a clock on the final drive enable only. The drive enable is held off in three cases: during the first cycle after a deselect, at once on a deselect, and on any write.

Top module: `burst_sram_core`

## Requirements
- R1: A read captured at edge k (controller strobe with no valid write control, processor strobe, or a burst continuation with no write control) presents the word {qp_o, q_o} at edge k+1, with q_oe high when oe_n is low and that edge is neither a write nor a deselect; the word is selected by addr_i[MEM_AW-1:0].
- R2: When cs1_n is high the processor strobe has no effect: it neither starts an access nor deselects, and with cstb_n high the cycle behaves as if no strobe were present.
- R3: A processor-strobe write takes two edges: the write controls and data at the capture edge are ignored, and the controls and data present at the next edge (no strobe, adv_n high) are written to the captured address.
- R4: With the controller strobe low, pstb_n high and all chip selects active (cs1_n low, cs2 high, cs3_n low), a valid write control writes the word at that same edge.
- R5: gw_n low writes all four lanes; otherwise bwe_n low writes only the lanes n whose bsel_n[n] is low (data bits 8n+7..8n and parity bit n), and the other lanes keep their contents.
- R6: An access that starts while the drive enable is off keeps q_oe low for the cycle that follows its start edge.
- R7: A strobe edge with any chip select inactive deselects the device, and q_oe is low right after that edge.
- R8: q_oe is low right after any write edge, whatever oe_n is.
- R9: With burst_mode 0 (linear), each continuation edge with adv_n low moves to the next address. The low two bits follow start+i modulo 4, and the upper bits stay fixed.
- R10: With burst_mode 1 (interleaved), the low two bits of the continuation address follow start XOR i.
- R11: A continuation edge with adv_n high keeps the current burst address.
- R12: oe_n high forces q_oe low without a clock edge, and it leaves the registered data unchanged.
- R13: After a synchronous reset, q_oe is low and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Access address |
| pstb_n | input | 1 | Processor address strobe, active low |
| cstb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low, also gates the processor strobe |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | 4 | Per-lane byte select, active low |
| burst_mode | input | 1 | Burst order: 0 linear, 1 interleaved (static) |
| oe_n | input | 1 | Asynchronous output enable, active low |
| d_i | input | 32 | Write data |
| dp_i | input | 4 | Write parity |
| q_o | output | 32 | Registered read data |
| qp_o | output | 4 | Registered read parity |
| q_oe | output | 1 | Drive enable for the shared data and parity pins |

## Verification
If the burst counter held a wrong count or base, the next continuation read would return a different word than the bench model predicts, one edge after the step. An access-type flag stuck at read would show up as q_oe high after a write edge. A lost write would show as stale lanes at the next read-back of that address. If the drive-enable register held a stale value, the first cycle after a deselect would show q_oe high immediately after the start edge.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int LANES  = 4;
    localparam int BYTE_W = 8;
    localparam int LANE_W = BYTE_W + 1;

    typedef logic [LANE_W-1:0] lane_t;
    typedef lane_t [LANES-1:0] word_t;

    typedef enum logic [1:0] {
        OP_IDLE,
        OP_READ,
        OP_WRITE,
        OP_DESEL
    } op_kind_e;

    typedef struct packed {
        op_kind_e          kind;
        logic              load;
        logic              step;
        logic [LANES-1:0]  wmask;
    } op_t;

    function automatic logic [1:0] burst_low(input logic [1:0] base,
                                             input logic [1:0] cnt,
                                             input logic       ilv);
        return ilv ? (base ^ cnt) : (base + cnt);
    endfunction

    function automatic logic [LANES-1:0] lane_mask(input logic gw_n,
                                                   input logic bwe_n,
                                                   input logic [LANES-1:0] bsel_n);
        if (!gw_n)
            return '1;
        else if (!bwe_n)
            return ~bsel_n;
        else
            return '0;
    endfunction

endpackage

// File: rtl/sram_access_decode.sv
module sram_access_decode
    import sram_pkg::*;
(
    input  logic             pstb_n,
    input  logic             cstb_n,
    input  logic             adv_n,
    input  logic             cs1_n,
    input  logic             cs2,
    input  logic             cs3_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bsel_n,
    input  logic             active,
    output op_t              op
);
    logic             p_go, any_go, selected;
    logic [LANES-1:0] mask;

    always_comb begin
        p_go     = !pstb_n && !cs1_n;
        any_go   = p_go || !cstb_n;
        selected = !cs1_n && cs2 && !cs3_n;
        mask     = lane_mask(gw_n, bwe_n, bsel_n);

        op       = '{kind: OP_IDLE, load: 1'b0, step: 1'b0, wmask: '0};
        if (any_go && !selected) begin
            op.kind = OP_DESEL;
        end else if (any_go) begin
            op.load = 1'b1;
            if (!p_go && (mask != '0)) begin
                op.kind  = OP_WRITE;
                op.wmask = mask;
            end else begin
                op.kind = OP_READ;
            end
        end else if (active) begin
            op.step = !adv_n;
            if (mask != '0) begin
                op.kind  = OP_WRITE;
                op.wmask = mask;
            end else begin
                op.kind = OP_READ;
            end
        end
    end

endmodule

// File: rtl/sram_burst_addr.sv
module sram_burst_addr
    import sram_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              burst_mode,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              load,
    input  logic              step,
    input  logic              desel,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              active
);
    logic [ADDR_W-1:0] base_q;
    logic [1:0]        cnt_q, cnt_use;
    logic              active_q;
    logic [ADDR_W-1:0] cur_addr;

    always_comb begin
        cnt_use  = step ? cnt_q + 2'd1 : cnt_q;
        cur_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_q, burst_mode)};
        if (load)
            acc_addr = addr_i;
        else
            acc_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_use, burst_mode)};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q   <= '0;
            cnt_q    <= '0;
            active_q <= 1'b0;
        end else if (desel) begin
            active_q <= 1'b0;
        end else if (load) begin
            base_q   <= addr_i;
            cnt_q    <= '0;
            active_q <= 1'b1;
        end else if (step) begin
            cnt_q    <= cnt_use;
        end
    end

    assign active = active_q;

    p_upper_fixed_r9: assert property (@(posedge clk) disable iff (rst)
        (step && !load && !desel) |=> cur_addr[ADDR_W-1:2] == $past(cur_addr[ADDR_W-1:2]));

    p_hold_addr_r11: assert property (@(posedge clk) disable iff (rst)
        (active_q && !step && !load && !desel && $stable(burst_mode)) |=> $stable(cnt_q) && $stable(base_q));

endmodule

// File: rtl/sram_store.sv
module sram_store
    import sram_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [LANES-1:0]  wmask,
    input  logic [MEM_AW-1:0] waddr,
    input  word_t             wdata,
    input  logic [MEM_AW-1:0] raddr,
    output word_t             rdata
);
    localparam int DEPTH = 1 << MEM_AW;

    for (genvar n = 0; n < LANES; n++) begin : g_lane
        lane_t mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && wmask[n])
                mem[waddr] <= wdata[n];
        end

        assign rdata[n] = mem[raddr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_pend,
    input  word_t rd_word,
    input  logic  wr_evt,
    input  logic  desel_evt,
    input  logic  oe_n,
    output word_t q_word,
    output logic  q_oe
);
    word_t q_q;
    logic  drive_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            q_q     <= '0;
            drive_q <= 1'b0;
        end else begin
            if (rd_pend)
                q_q <= rd_word;
            if (wr_evt || desel_evt)
                drive_q <= 1'b0;
            else if (rd_pend)
                drive_q <= 1'b1;
        end
    end

    assign q_word = q_q;
    assign q_oe   = drive_q && !oe_n;

    p_read_visible_r1: assert property (@(posedge clk) disable iff (rst)
        (rd_pend && !wr_evt && !desel_evt) |=> drive_q && (q_q == $past(rd_word)));

    p_first_cycle_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!drive_q && !rd_pend) |=> !drive_q);

    p_desel_off_r7: assert property (@(posedge clk) disable iff (rst)
        desel_evt |=> !drive_q);

    p_write_off_r8: assert property (@(posedge clk) disable iff (rst)
        wr_evt |=> !drive_q);

endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
    import sram_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              pstb_n,
    input  logic              cstb_n,
    input  logic              adv_n,
    input  logic              cs1_n,
    input  logic              cs2,
    input  logic              cs3_n,
    input  logic              gw_n,
    input  logic              bwe_n,
    input  logic [3:0]        bsel_n,
    input  logic              burst_mode,
    input  logic              oe_n,
    input  logic [31:0]       d_i,
    input  logic [3:0]        dp_i,
    output logic [31:0]       q_o,
    output logic [3:0]        qp_o,
    output logic              q_oe
);
    op_t               op;
    logic              active;
    logic [ADDR_W-1:0] acc_addr;
    logic              rd1_q;
    logic [MEM_AW-1:0] rd_addr_q;
    word_t             wr_word, rd_word, q_word;
    logic              is_wr, is_desel;

    sram_access_decode u_dec (
        .pstb_n (pstb_n), .cstb_n (cstb_n), .adv_n (adv_n),
        .cs1_n  (cs1_n),  .cs2    (cs2),    .cs3_n (cs3_n),
        .gw_n   (gw_n),   .bwe_n  (bwe_n),  .bsel_n (bsel_n),
        .active (active), .op     (op)
    );

    assign is_wr    = (op.kind == OP_WRITE);
    assign is_desel = (op.kind == OP_DESEL);

    sram_burst_addr #(.ADDR_W(ADDR_W)) u_burst (
        .clk (clk), .rst (rst), .burst_mode (burst_mode), .addr_i (addr_i),
        .load (op.load), .step (op.step), .desel (is_desel),
        .acc_addr (acc_addr), .active (active)
    );

    for (genvar n = 0; n < LANES; n++) begin : g_pack
        assign wr_word[n]                  = {dp_i[n], d_i[BYTE_W*n +: BYTE_W]};
        assign q_o[BYTE_W*n +: BYTE_W]     = q_word[n][BYTE_W-1:0];
        assign qp_o[n]                     = q_word[n][BYTE_W];
    end

    sram_store #(.MEM_AW(MEM_AW)) u_store (
        .clk (clk), .we (is_wr), .wmask (op.wmask),
        .waddr (acc_addr[MEM_AW-1:0]), .wdata (wr_word),
        .raddr (rd_addr_q), .rdata (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd1_q     <= 1'b0;
            rd_addr_q <= '0;
        end else begin
            rd1_q     <= (op.kind == OP_READ);
            rd_addr_q <= acc_addr[MEM_AW-1:0];
        end
    end

    sram_out_stage u_out (
        .clk (clk), .rst (rst), .rd_pend (rd1_q), .rd_word (rd_word),
        .wr_evt (is_wr), .desel_evt (is_desel), .oe_n (oe_n),
        .q_word (q_word), .q_oe (q_oe)
    );

    p_pstb_gated_r2: assert property (@(posedge clk) disable iff (rst)
        (cs1_n && cstb_n && !active) |=> !rd1_q);

    p_reset_idle_r13: assert property (@(posedge clk)
        rst |=> !active && !rd1_q);

endmodule

// File: tb/burst_sram_core_test.sv
module burst_sram_core_test;
    localparam int ADDR_W = 17;
    localparam int MEM_AW = 8;

    logic              clk = 1'b0;
    logic              rst;
    logic [ADDR_W-1:0] addr_i;
    logic              pstb_n, cstb_n, adv_n, cs1_n, cs2, cs3_n;
    logic              gw_n, bwe_n, burst_mode, oe_n;
    logic [3:0]        bsel_n;
    logic [31:0]       d_i;
    logic [3:0]        dp_i;
    logic [31:0]       q_o;
    logic [3:0]        qp_o;
    logic              q_oe;

    int unsigned n_tests = 0;
    int unsigned n_fail  = 0;
    logic [35:0] model [1 << MEM_AW];

    burst_sram_core #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) uut (
        .clk (clk), .rst (rst), .addr_i (addr_i), .pstb_n (pstb_n), .cstb_n (cstb_n),
        .adv_n (adv_n), .cs1_n (cs1_n), .cs2 (cs2), .cs3_n (cs3_n), .gw_n (gw_n),
        .bwe_n (bwe_n), .bsel_n (bsel_n), .burst_mode (burst_mode), .oe_n (oe_n),
        .d_i (d_i), .dp_i (dp_i), .q_o (q_o), .qp_o (qp_o), .q_oe (q_oe)
    );

    always #5 clk = ~clk;

    function automatic logic [35:0] merge(input logic [35:0] old, input logic [35:0] nw,
                                          input logic [3:0] m);
        logic [35:0] r = old;
        for (int n = 0; n < 4; n++) begin
            if (m[n]) begin
                r[8*n +: 8] = nw[8*n +: 8];
                r[32+n]     = nw[32+n];
            end
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_mask(input logic g, input logic b, input logic [3:0] bs);
        if (!g) return 4'hF;
        if (!b) return ~bs;
        return 4'h0;
    endfunction

    function automatic logic [1:0] seq_low(input logic [1:0] base, input int i, input logic ilv);
        logic [1:0] c = i[1:0];
        return ilv ? (base ^ c) : (base + c);
    endfunction

    task automatic check(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic set_idle();
        pstb_n = 1; cstb_n = 1; adv_n = 1; gw_n = 1; bwe_n = 1; bsel_n = 4'hF;
        cs1_n = 0; cs2 = 1; cs3_n = 0;
    endtask

    task automatic deselect();
        set_idle(); cstb_n = 0; cs2 = 0;
        tick();
        check("R7 deselect off", {35'd0, q_oe}, 36'd0);
        set_idle();
    endtask

    task automatic cwrite(input logic [ADDR_W-1:0] a, input logic [35:0] w,
                          input logic g, input logic b, input logic [3:0] bs, input bit chk);
        set_idle(); addr_i = a; cstb_n = 0; gw_n = g; bwe_n = b; bsel_n = bs;
        {dp_i, d_i} = w;
        tick();
        model[a[MEM_AW-1:0]] = merge(model[a[MEM_AW-1:0]], w, exp_mask(g, b, bs));
        if (chk) check("R8 write off R4", {35'd0, q_oe}, 36'd0);
        set_idle();
    endtask

    task automatic pwrite(input logic [ADDR_W-1:0] a, input logic [35:0] w,
                          input logic g, input logic b, input logic [3:0] bs);
        set_idle(); addr_i = a; pstb_n = 0; gw_n = 0; bwe_n = 0; bsel_n = 4'h0;
        {dp_i, d_i} = ~w;
        tick();
        set_idle(); gw_n = g; bwe_n = b; bsel_n = bs; {dp_i, d_i} = w;
        addr_i = ~a;
        tick();
        model[a[MEM_AW-1:0]] = merge(model[a[MEM_AW-1:0]], w, exp_mask(g, b, bs));
        check("R3 R8 second edge write off", {35'd0, q_oe}, 36'd0);
        set_idle();
    endtask

    task automatic cread(input logic [ADDR_W-1:0] a, input bit first_off, input string req);
        set_idle(); addr_i = a; cstb_n = 0;
        tick();
        if (first_off) check("R6 first cycle off", {35'd0, q_oe}, 36'd0);
        set_idle();
        tick();
        check(req, {qp_o, q_o}, model[a[MEM_AW-1:0]]);
        check("R1 drive on", {35'd0, q_oe}, 36'd1);
    endtask

    task automatic burst(input logic [ADDR_W-1:0] a, input logic ilv, input string req);
        logic [ADDR_W-1:0] blk;
        burst_mode = ilv;
        set_idle(); addr_i = a; cstb_n = 0;
        tick();
        set_idle(); adv_n = 0;
        for (int j = 1; j <= 6; j++) begin
            tick();
            blk = {a[ADDR_W-1:2], seq_low(a[1:0], j - 1, ilv)};
            check(req, {qp_o, q_o}, model[blk[MEM_AW-1:0]]);
        end
        adv_n = 1;
        blk = {a[ADDR_W-1:2], seq_low(a[1:0], 6, ilv)};
        for (int j = 0; j < 2; j++) begin
            tick();
            check("R11 hold", {qp_o, q_o}, model[blk[MEM_AW-1:0]]);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [35:0]       w;
        logic [ADDR_W-1:0] a;
        logic [35:0]       held;
        int unsigned       seed;
        seed = $urandom(32'd2718);
        set_idle();
        addr_i = '0; d_i = '0; dp_i = '0; burst_mode = 0; oe_n = 0; rst = 1;
        repeat (3) tick();
        rst = 0;
        check("R13 reset off", {35'd0, q_oe}, 36'd0);
        tick(); tick();
        check("R13 idle stays off", {35'd0, q_oe}, 36'd0);

        for (int i = 0; i < (1 << MEM_AW); i++)
            cwrite(ADDR_W'(i), {4'(i), 32'(i * 32'h01010101) ^ 32'hA5A5_0000}, 0, 1, 4'hF, 0);

        deselect();
        cread(17'h00011, 1, "R1 read after deselect");
        cwrite(17'h00022, 36'h9_1234_5678, 0, 1, 4'hF, 1);
        cread(17'h00022, 1, "R4 global write readback");
        cwrite(17'h00022, 36'h6_AABB_CCDD, 1, 0, 4'b1010, 1);
        cread(17'h00022, 0, "R5 byte lanes 0 and 2");
        cwrite(17'h00022, 36'hF_0000_0000, 0, 0, 4'b1110, 1);
        cread(17'h00022, 0, "R5 global overrides bytes");
        pwrite(17'h00033, 36'h3_0F0F_0F0F, 1, 0, 4'b1101);
        cread(17'h00033, 0, "R3 processor write lane1");

        // R12 asynchronous output enable
        held = {qp_o, q_o};
        oe_n = 1; #1;
        check("R12 oe_n forces off", {35'd0, q_oe}, 36'd0);
        check("R12 data kept", {qp_o, q_o}, held);
        oe_n = 0; #1;
        check("R12 drive back", {35'd0, q_oe}, 36'd1);

        // R2 processor strobe with cs1_n high during active read
        set_idle(); pstb_n = 0; cs1_n = 1;
        tick();
        check("R2 no deselect", {35'd0, q_oe}, 36'd1);
        check("R2 data kept", {qp_o, q_o}, model[8'h33]);
        deselect();
        set_idle(); pstb_n = 0; cs1_n = 1; addr_i = 17'h00044;
        tick(); tick();
        check("R2 ignored while deselected", {35'd0, q_oe}, 36'd0);
        set_idle();

        burst(17'h00041, 0, "R9 linear burst");
        burst(17'h1A061, 1, "R10 interleaved burst");
        burst(17'h00082, 1, "R10 interleaved burst base 2");
        burst_mode = 0;

        for (int k = 0; k < 300; k++) begin
            a = ADDR_W'($urandom);
            w = {4'($urandom), 32'($urandom)};
            case ($urandom % 6)
                0: cwrite(a, w, ($urandom % 4) != 0, 0, 4'($urandom % 15), 1);
                1: pwrite(a, w, ($urandom % 3) != 0, 0, 4'($urandom % 15));
                2: deselect();
                default: cread(a, 0, "R1 random read");
            endcase
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule